// File: doc/BRIEF.md
# Packed-Lane Immediate Left Shifter

This block executes a single vector instruction: a logical left shift by an immediate applied to every lane of a wide packed operand. A 32-bit instruction word and a source vector arrive together with a valid strobe. The block checks the word against its fixed opcode bits. A 4-bit size code selects the lane width from its most significant set bit. The shift count is recovered by subtracting that lane width from the 7-bit value formed by the size code followed by a 3-bit immediate. Every lane is shifted on its own, and bits that leave a lane are dropped.

One cycle after an accepted input, the block presents either a valid result with its destination register index, or an undefined-instruction flag. The vector length is a parameter, a multiple of 64 bits, with a default of 256. A new input can be accepted on every cycle.

Top module: `vlsl_imm_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_undef`, `out_vec` and `out_dst` are all zero.
- R2: A word is recognised only if bits 31..24 equal 8'h04, bit 21 is 1 and bits 15..10 equal 6'b100111. A strobed word that fails any of these gives `out_undef`=1 and `out_valid`=0 one cycle later.
- R3: The size code is {bits 23..22, bits 20..19}. A strobed, recognised word whose size code is 4'b0000 gives `out_undef`=1 and `out_valid`=0 one cycle later.
- R4: The shift count is the unsigned 7-bit value {size code, bits 18..16} minus the lane width. A size code of 4'b0001 selects 8-bit lanes.
- R5: A size code of the form 001x selects 16-bit lanes.
- R6: A size code of the form 01xx selects 32-bit lanes.
- R7: A size code of the form 1xxx selects 64-bit lanes.
- R8: Each lane is shifted independently. Bits shifted past the top of a lane are lost and never enter the next lane, vacated low bits are zero, and every lane of the result is written.
- R9: A strobed legal word gives `out_valid`=1 and `out_undef`=0 exactly one cycle later, with `out_dst` equal to bits 4..0 of that word.
- R10: In a cycle with `in_valid` low, the next cycle shows `out_valid`=0 and `out_undef`=0.
- R11: `out_vec` and `out_dst` keep their previous values after a cycle with no input or with an undefined word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input strobe |
| in_instr | input | 32 | Instruction word |
| in_vec | input | VLEN | Source vector operand |
| out_valid | output | 1 | Result valid, one cycle after a legal input |
| out_undef | output | 1 | Undefined-instruction flag, one cycle after an illegal input |
| out_vec | output | VLEN | Shifted result vector |
| out_dst | output | 5 | Destination register index |

## Verification
The undefined-instruction flag and the hold of the previous result can occur in the same cycle. When an illegal word follows a legal one back to back, the flag must rise while `out_vec` and `out_dst` still show the earlier result. The bench provokes this with random streams that mix legal words with words that have one opcode bit flipped or a zero size code, sent on consecutive cycles and separated by idle gaps. Each cycle it checks the flag pair against the class of the word sent, and checks that the held vector and index match the last legal result computed by its own lane-by-lane reference.

// File: rtl/vlsl_pkg.sv
package vlsl_pkg;

  // Lane width selector; value w means 8 << w bits per lane.
  typedef enum logic [1:0] {
    LW8  = 2'd0,
    LW16 = 2'd1,
    LW32 = 2'd2,
    LW64 = 2'd3
  } lane_w_e;

  typedef struct packed {
    logic    legal;
    lane_w_e width;
    logic [5:0] shamt;
    logic [4:0] dst;
  } vlsl_dec_t;

  localparam logic [7:0] OPC_TOP = 8'h04;
  localparam logic [5:0] OPC_MID = 6'b100111;
  localparam int unsigned CHUNK_W = 64;

endpackage

// File: rtl/vlsl_decode.sv
module vlsl_decode
  import vlsl_pkg::*;
(
  input  logic [31:0] instr,
  output vlsl_dec_t   dec
);

  logic [3:0] tsize;
  logic [6:0] packed_imm;
  logic [6:0] esize;
  logic [6:0] diff;
  logic       opc_hit;

  always_comb begin
    tsize      = {instr[23:22], instr[20:19]};
    packed_imm = {tsize, instr[18:16]};
    opc_hit    = (instr[31:24] == OPC_TOP) && instr[21] && (instr[15:10] == OPC_MID);

    // Leading one of the size code selects the lane width.
    if (tsize[3]) begin
      dec.width = LW64;
      esize     = 7'd64;
    end else if (tsize[2]) begin
      dec.width = LW32;
      esize     = 7'd32;
    end else if (tsize[1]) begin
      dec.width = LW16;
      esize     = 7'd16;
    end else begin
      dec.width = LW8;
      esize     = 7'd8;
    end

    diff      = packed_imm - esize;
    dec.shamt = diff[5:0];
    dec.dst   = instr[4:0];
    dec.legal = opc_hit && (tsize != 4'b0000);
  end

endmodule

// File: rtl/vlsl_chunk_shift.sv
module vlsl_chunk_shift
  import vlsl_pkg::*;
#(
  parameter int unsigned CW = CHUNK_W
) (
  input  logic [CW-1:0] din,
  input  lane_w_e       width,
  input  logic [5:0]    shamt,
  output logic [CW-1:0] dout
);

  logic [3:0][CW-1:0] cand;

  // One candidate per lane width; the shift amount is cut to log2(lane) bits.
  for (genvar w = 0; w < 4; w++) begin : g_width
    localparam int unsigned EW = 8 << w;
    localparam int unsigned NL = CW / EW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign cand[w][l*EW +: EW] = din[l*EW +: EW] << shamt[w+2:0];
    end
  end

  always_comb begin
    dout = cand[width];
  end

endmodule

// File: rtl/vlsl_imm_unit.sv
module vlsl_imm_unit
  import vlsl_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  input  logic [VLEN-1:0] in_vec,
  output logic            out_valid,
  output logic            out_undef,
  output logic [VLEN-1:0] out_vec,
  output logic [4:0]      out_dst
);

  // VLEN must be a multiple of the 64-bit chunk.
  localparam int unsigned NCHUNK = VLEN / CHUNK_W;

  vlsl_dec_t       dec;
  logic [VLEN-1:0] shifted;
  logic            accept;
  logic            valid_nxt;
  logic            undef_nxt;
  logic [VLEN-1:0] vec_nxt;
  logic [4:0]      dst_nxt;

  vlsl_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    vlsl_chunk_shift #(.CW(CHUNK_W)) u_sh (
      .din   (in_vec[c*CHUNK_W +: CHUNK_W]),
      .width (dec.width),
      .shamt (dec.shamt),
      .dout  (shifted[c*CHUNK_W +: CHUNK_W])
    );
  end

  // Next-state logic
  always_comb begin
    accept    = in_valid && dec.legal;
    valid_nxt = accept;
    undef_nxt = in_valid && !dec.legal;
    vec_nxt   = out_vec;
    dst_nxt   = out_dst;
    if (accept) begin
      vec_nxt = shifted;
      dst_nxt = dec.dst;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
      out_undef <= undef_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vec <= '0;
      out_dst <= '0;
    end else if (accept) begin
      out_vec <= vec_nxt;
      out_dst <= dst_nxt;
    end
  end

endmodule

// File: rtl/vlsl_check.sv
module vlsl_check #(
  parameter int unsigned VLEN = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     in_instr,
  input logic [VLEN-1:0] in_vec,
  input logic            out_valid,
  input logic            out_undef,
  input logic [VLEN-1:0] out_vec,
  input logic [4:0]      out_dst
);

  logic       fixed_ok;
  logic [3:0] tsz;
  logic       good;

  assign fixed_ok = (in_instr[31:24] == 8'h04) && in_instr[21] && (in_instr[15:10] == 6'b100111);
  assign tsz      = {in_instr[23:22], in_instr[20:19]};
  assign good     = fixed_ok && (tsz != 4'd0);

  p_flag_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_undef));

  p_bad_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fixed_ok) |=> (out_undef && !out_valid));

  p_zero_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fixed_ok && tsz == 4'd0) |=> (out_undef && !out_valid));

  // R4..R7: a one-hot size code with imm3 = 0 gives a zero shift count
  p_zero_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && good && $onehot0(tsz) && in_instr[18:16] == 3'd0) |=> (out_vec == $past(in_vec)));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && good) |=> (out_valid && !out_undef && out_dst == $past(in_instr[4:0])));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_undef));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && good) |=> ($stable(out_vec) && $stable(out_dst)));

endmodule

bind vlsl_imm_unit vlsl_check #(.VLEN(VLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_instr  (in_instr),
  .in_vec    (in_vec),
  .out_valid (out_valid),
  .out_undef (out_undef),
  .out_vec   (out_vec),
  .out_dst   (out_dst)
);

// File: tb/tb_vlsl_imm_unit.sv
module tb_vlsl_imm_unit;

  localparam int unsigned VLEN = 256;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     in_instr;
  logic [VLEN-1:0] in_vec;
  logic            out_valid;
  logic            out_undef;
  logic [VLEN-1:0] out_vec;
  logic [4:0]      out_dst;

  int checks;
  int errors;
  logic [VLEN-1:0] hold_vec;
  logic [4:0]      hold_dst;

  vlsl_imm_unit #(.VLEN(VLEN)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_instr  (in_instr),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_undef (out_undef),
    .out_vec   (out_vec),
    .out_dst   (out_dst)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] enc(input logic [6:0] szimm, input logic [4:0] zn, input logic [4:0] zd);
    return {8'h04, szimm[6:5], 1'b1, szimm[4:3], szimm[2:0], 6'b100111, zn, zd};
  endfunction

  function automatic logic [VLEN-1:0] ref_lsl(input logic [VLEN-1:0] v, input int esize, input int sh);
    logic [VLEN-1:0] r;
    for (int i = 0; i < VLEN; i++) begin
      int pos = i % esize;
      r[i] = (pos >= sh) ? v[i-sh] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rand_vec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk1(input string req, input string what, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic do_legal(input string req, input int esize, input int sh, input logic [VLEN-1:0] v, input logic [4:0] zd);
    logic [VLEN-1:0] e;
    in_valid = 1'b1;
    in_instr = enc(7'(esize + sh), 5'($urandom), zd);
    in_vec   = v;
    e = ref_lsl(v, esize, sh);
    @(negedge clk);
    chk1("R9", "out_valid", VLEN'(out_valid), VLEN'(1));
    chk1("R9", "out_undef", VLEN'(out_undef), VLEN'(0));
    chk1("R9", "out_dst", VLEN'(out_dst), VLEN'(zd));
    chk1(req, "out_vec", out_vec, e);
    hold_vec = e;
    hold_dst = zd;
  endtask

  task automatic do_illegal(input string req, input logic [31:0] w);
    in_valid = 1'b1;
    in_instr = w;
    in_vec   = rand_vec();
    @(negedge clk);
    chk1(req, "out_undef", VLEN'(out_undef), VLEN'(1));
    chk1(req, "out_valid", VLEN'(out_valid), VLEN'(0));
    chk1("R11", "held out_vec", out_vec, hold_vec);
    chk1("R11", "held out_dst", VLEN'(out_dst), VLEN'(hold_dst));
  endtask

  task automatic do_idle();
    in_valid = 1'b0;
    in_instr = $urandom;
    in_vec   = rand_vec();
    @(negedge clk);
    chk1("R10", "out_valid", VLEN'(out_valid), VLEN'(0));
    chk1("R10", "out_undef", VLEN'(out_undef), VLEN'(0));
    chk1("R11", "held out_vec", out_vec, hold_vec);
  endtask

  function automatic logic [31:0] flip_fixed(input logic [31:0] w, input int j);
    int b;
    if (j < 8) b = 24 + j;
    else if (j == 8) b = 21;
    else b = 10 + (j - 9);
    w[b] = ~w[b];
    return w;
  endfunction

  function automatic string width_req(input int esize);
    case (esize)
      8:  return "R4";
      16: return "R5";
      32: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    hold_vec = '0;
    hold_dst = '0;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_instr = '0;
    in_vec = '0;
    repeat (3) @(negedge clk);
    chk1("R1", "out_valid", VLEN'(out_valid), VLEN'(0));
    chk1("R1", "out_undef", VLEN'(out_undef), VLEN'(0));
    chk1("R1", "out_vec", out_vec, '0);
    chk1("R1", "out_dst", VLEN'(out_dst), VLEN'(0));
    rst_n = 1'b1;

    // Directed: each width at shift 0 and lane width minus 1 (R8 on all-ones)
    for (int w = 0; w < 4; w++) begin
      int es = 8 << w;
      do_legal(width_req(es), es, 0, rand_vec(), 5'(w));
      do_legal("R8", es, es - 1, '1, 5'(w + 8));
      do_legal(width_req(es), es, es / 2 - 1, rand_vec(), 5'(w + 16));
    end
    // Non-minimal size codes still pick the width by the leading one (R5..R7)
    do_legal("R5", 16, 15, rand_vec(), 5'd3);
    do_legal("R6", 32, 31, rand_vec(), 5'd4);
    do_legal("R7", 64, 63, rand_vec(), 5'd31);
    // Zero size code with nonzero imm3, back to back after a legal word
    do_illegal("R3", enc(7'b0000_101, 5'd1, 5'd2));
    do_illegal("R3", enc(7'b0000_000, 5'd1, 5'd2));
    do_idle();
    for (int j = 0; j < 15; j++) do_illegal("R2", flip_fixed(enc(7'd9, 5'd0, 5'd7), j));

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int kind = $urandom % 10;
      if (kind < 6) begin
        int es = 8 << ($urandom % 4);
        do_legal(width_req(es), es, $urandom % es, rand_vec(), 5'($urandom));
      end else if (kind < 8) begin
        do_illegal("R2", flip_fixed(enc(7'(8 + ($urandom % 120)), 5'($urandom), 5'($urandom)), $urandom % 15));
      end else if (kind == 8) begin
        do_illegal("R3", enc({4'b0000, 3'($urandom)}, 5'($urandom), 5'($urandom)));
      end else begin
        do_idle();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule